// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits between an execution core and a simple memory port. While the core works, the block reads instruction bytes ahead of it into a small byte FIFO. The core takes bytes from the head of the FIFO through a pop interface with a valid flag. The core has no memory port of its own. Its data loads and stores are handed to this block and carried out on the same memory port. A redirect command empties the FIFO and restarts fetching at a new address.

The parameter `BUS_W` selects the bus variant. With a 16-bit bus the FIFO holds six bytes, and a fetch starts only when a whole bus word of space is free. With an 8-bit bus the FIFO holds four bytes, and a fetch starts as soon as one slot is free.

The bus controller is a four-state machine: `BIU_IDLE`, `BIU_FETCH`, `BIU_DATA` and `BIU_DATA_END`. Its transitions are:

- `BIU_IDLE -> BIU_DATA` when a data request is pending. This has priority.
- `BIU_IDLE -> BIU_FETCH` when there is room in the FIFO and no redirect this cycle.
- `BIU_FETCH -> BIU_IDLE` on `mem_ready`.
- `BIU_DATA -> BIU_DATA_END` on `mem_ready`.
- `BIU_DATA_END -> BIU_IDLE` always. This is the single cycle in which `ddone` is shown.

Top module: `ipq_unit`

## Requirements
- R1: While `rst_n` is low, `q_valid` and `mem_req` are 0. After reset the FIFO is empty and the first bus request is an instruction fetch at `START_ADDR`.
- R2: The FIFO holds at most 6 bytes when `BUS_W`=16 and at most 4 bytes when `BUS_W`=8. Once it is full, no further fetch is issued until bytes are popped.
- R3: When `BUS_W`=16, a fetch starts only when at least 2 slots are free. When `BUS_W`=8, a fetch starts when at least 1 slot is free.
- R4: Bytes are presented on `q_byte` in the order of their fetch addresses, first in first out.
- R5: On the 16-bit bus, the byte at an even address travels on data bits [7:0] and the byte at the following odd address travels on bits [15:8]. The fetch pointer advances by the number of bytes accepted.
- R6: On the 16-bit bus, a fetch at an odd address accepts only the byte on bits [15:8]. The next fetch uses the following even address and accepts two bytes.
- R7: A `redir` pulse empties the FIFO, so `q_valid` is 0 in the next cycle. The next byte presented is the byte at `redir_addr`.
- R8: If a fetch is still on the bus when `redir` is asserted, that fetch completes but its returned bytes are discarded.
- R9: A `q_pop` while `q_valid` is 0 has no effect. The core stalls until a byte arrives, and no byte is lost.
- R10: A data access drives `daddr` on `mem_addr`, and drives `dwe` and `dwdata` on `mem_we` and `mem_wdata`. One cycle after the bus cycle completes, `ddone` is high for exactly one cycle and `drdata` holds the read word. For 16-bit accesses the address is even.
- R11: A pending data request wins over a new fetch. A fetch already on the bus finishes first, and the data access is the next bus cycle.
- R12: While `mem_req` is high and `mem_ready` is low, `mem_addr` and `mem_we` hold their values and `mem_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | BUS_W | Write data |
| mem_rdata | input | BUS_W | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Bus cycle completes at this edge |
| q_byte | output | 8 | Byte at the head of the FIFO |
| q_valid | output | 1 | `q_byte` is valid |
| q_pop | input | 1 | Remove the head byte |
| dreq | input | 1 | Data access request, held until `ddone` |
| dwe | input | 1 | Data access is a write |
| daddr | input | ADDR_W | Data address |
| dwdata | input | BUS_W | Data to store |
| drdata | output | BUS_W | Loaded data, valid with `ddone` |
| ddone | output | 1 | Data access finished (one-cycle pulse) |
| redir | input | 1 | Flush the FIFO and restart fetching |
| redir_addr | input | ADDR_W | New fetch address |

## Verification
Each result in this block has a fixed latency, counted in edges:

| Stimulus | Result | Due |
|---|---|---|
| Room appears in the FIFO | `mem_req` rises for a fetch | first edge |
| Data request while the bus is idle | `mem_req` rises for the data access | first edge |
| Edge at which `mem_ready` is sampled | Fetched bytes visible on `q_byte` | next cycle |
| Edge at which `mem_ready` is sampled | `ddone` | following cycle, for exactly one cycle |
| `redir` | `q_valid` low | first edge |

The bench drives every input on the falling edge and samples on the falling edge, so each observation falls half a period after the register that produces it. For occupancy limits and bus ordering, the bench does not try to catch a single-cycle event. It waits a bounded number of cycles for the bus to settle, then compares the memory model's log of completed bus cycles with the expected addresses and counts.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

    typedef enum logic [1:0] {
        BIU_IDLE,
        BIU_FETCH,
        BIU_DATA,
        BIU_DATA_END
    } biu_state_e;

    function automatic int queue_depth(input int bus_w);
        return (bus_w == 16) ? 6 : 4;
    endfunction

endpackage

// File: rtl/ipq_fifo.sv
module ipq_fifo #(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       wr_n,
    input  logic [7:0]       wr_b0,
    input  logic [7:0]       wr_b1,
    input  logic             pop,
    output logic [7:0]       head,
    output logic             valid,
    output logic [CNT_W-1:0] count
);
    logic [DEPTH-1:0][7:0] slot_q;
    logic [DEPTH-1:0][7:0] slot_nxt;
    logic                  pop_eff;
    logic [CNT_W-1:0]      base;
    logic [CNT_W-1:0]      base_p1;
    logic [CNT_W-1:0]      count_nxt;

    assign pop_eff = pop && (count != '0);
    assign base    = count - CNT_W'(pop_eff);
    assign base_p1 = base + CNT_W'(1);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [7:0] kept;
        if (i == DEPTH - 1) begin : g_last
            assign kept = pop_eff ? 8'h00 : slot_q[i];
        end else begin : g_mid
            assign kept = pop_eff ? slot_q[i+1] : slot_q[i];
        end
        assign slot_nxt[i] =
            (wr_n == 2'd2 && base_p1 == CNT_W'(i)) ? wr_b1 :
            (wr_n != 2'd0 && base == CNT_W'(i))    ? wr_b0 : kept;
    end

    always_comb begin
        if (flush) begin
            count_nxt = '0;
        end else begin
            count_nxt = count - CNT_W'(pop_eff) + CNT_W'(wr_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            count  <= '0;
        end else begin
            slot_q <= slot_nxt;
            count  <= count_nxt;
        end
    end

    assign head  = slot_q[0];
    assign valid = (count != '0);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n != 2'd0) |-> (int'(count) - int'(pop_eff) + int'(wr_n) <= DEPTH));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && wr_n == 2'd0) |=> !valid);

endmodule

// File: rtl/ipq_fetch_ptr.sv
module ipq_fetch_ptr #(
    parameter int              ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir,
    input  logic [ADDR_W-1:0] redir_addr,
    input  logic [1:0]        adv,
    output logic [ADDR_W-1:0] ip
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip <= START_ADDR;
        end else if (redir) begin
            ip <= redir_addr;
        end else begin
            ip <= ip + ADDR_W'(adv);
        end
    end

    // R5
    ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir && adv == 2'd0) |=> $stable(ip));

endmodule

// File: rtl/ipq_bus_ctrl.sv
module ipq_bus_ctrl
    import ipq_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [ADDR_W-1:0] ip,
    input  logic              redir,
    input  logic              dreq,
    input  logic              dwe,
    input  logic [ADDR_W-1:0] daddr,
    input  logic [BUS_W-1:0]  dwdata,
    input  logic [BUS_W-1:0]  mem_rdata,
    input  logic              mem_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    output logic              ddone,
    output logic [BUS_W-1:0]  drdata,
    output logic [1:0]        enq_n,
    output logic [7:0]        enq_b0,
    output logic [7:0]        enq_b1
);
    localparam int BPW = BUS_W / 8;

    biu_state_e        state;
    biu_state_e        state_nxt;
    logic [ADDR_W-1:0] bus_addr;
    logic [BUS_W-1:0]  wdata_q;
    logic [BUS_W-1:0]  drdata_q;
    logic              we_q;
    logic              drop_q;
    logic [CNT_W-1:0]  free_slots;
    logic              room;
    logic              keep;

    assign free_slots = CNT_W'(DEPTH) - fifo_count;
    assign room       = free_slots >= CNT_W'(BPW);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            BIU_IDLE: begin
                if (dreq) begin
                    state_nxt = BIU_DATA;
                end else if (room && !redir) begin
                    state_nxt = BIU_FETCH;
                end
            end
            BIU_FETCH: begin
                if (mem_ready) state_nxt = BIU_IDLE;
            end
            BIU_DATA: begin
                if (mem_ready) state_nxt = BIU_DATA_END;
            end
            BIU_DATA_END: begin
                state_nxt = BIU_IDLE;
            end
            default: state_nxt = BIU_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BIU_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // cycle-attribute registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
            wdata_q  <= '0;
            we_q     <= 1'b0;
            drop_q   <= 1'b0;
            drdata_q <= '0;
        end else begin
            unique case (state)
                BIU_IDLE: begin
                    drop_q <= 1'b0;
                    if (dreq) begin
                        bus_addr <= daddr;
                        we_q     <= dwe;
                        wdata_q  <= dwdata;
                    end else if (room && !redir) begin
                        bus_addr <= ip;
                        we_q     <= 1'b0;
                    end
                end
                BIU_FETCH: begin
                    if (redir && !mem_ready) drop_q <= 1'b1;
                end
                BIU_DATA: begin
                    if (mem_ready) drdata_q <= mem_rdata;
                end
                BIU_DATA_END: begin
                    drop_q <= 1'b0;
                end
                default: drop_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state == BIU_FETCH) || (state == BIU_DATA);
        mem_we    = (state == BIU_DATA) && we_q;
        mem_addr  = bus_addr;
        mem_wdata = wdata_q;
        ddone     = (state == BIU_DATA_END);
        drdata    = drdata_q;
    end

    assign keep = (state == BIU_FETCH) && mem_ready && !drop_q && !redir;

    if (BUS_W == 16) begin : g_wide
        always_comb begin
            enq_n  = 2'd0;
            enq_b0 = mem_rdata[7:0];
            enq_b1 = mem_rdata[15:8];
            if (keep) begin
                if (bus_addr[0]) begin
                    enq_n  = 2'd1;
                    enq_b0 = mem_rdata[15:8];
                end else begin
                    enq_n  = 2'd2;
                end
            end
        end
    end else begin : g_narrow
        always_comb begin
            enq_n  = keep ? 2'd1 : 2'd0;
            enq_b0 = mem_rdata[7:0];
            enq_b1 = 8'h00;
        end
    end

    // R12
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    ddone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ddone |=> !ddone);

    // R8
    drop_no_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |-> (enq_n == 2'd0));

endmodule

// File: rtl/ipq_unit.sv
module ipq_unit #(
    parameter int                BUS_W      = 16,
    parameter int                ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] START_ADDR = 20'h00100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    input  logic [BUS_W-1:0]  mem_rdata,
    input  logic              mem_ready,
    output logic [7:0]        q_byte,
    output logic              q_valid,
    input  logic              q_pop,
    input  logic              dreq,
    input  logic              dwe,
    input  logic [ADDR_W-1:0] daddr,
    input  logic [BUS_W-1:0]  dwdata,
    output logic [BUS_W-1:0]  drdata,
    output logic              ddone,
    input  logic              redir,
    input  logic [ADDR_W-1:0] redir_addr
);
    localparam int DEPTH = ipq_pkg::queue_depth(BUS_W);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  fifo_count;
    logic [ADDR_W-1:0] ip;
    logic [1:0]        enq_n;
    logic [7:0]        enq_b0;
    logic [7:0]        enq_b1;

    ipq_fetch_ptr #(
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR)
    ) ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .redir      (redir),
        .redir_addr (redir_addr),
        .adv        (enq_n),
        .ip         (ip)
    );

    ipq_bus_ctrl #(
        .BUS_W  (BUS_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_count (fifo_count),
        .ip         (ip),
        .redir      (redir),
        .dreq       (dreq),
        .dwe        (dwe),
        .daddr      (daddr),
        .dwdata     (dwdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .ddone      (ddone),
        .drdata     (drdata),
        .enq_n      (enq_n),
        .enq_b0     (enq_b0),
        .enq_b1     (enq_b1)
    );

    ipq_fifo #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (redir),
        .wr_n  (enq_n),
        .wr_b0 (enq_b0),
        .wr_b1 (enq_b1),
        .pop   (q_pop),
        .head  (q_byte),
        .valid (q_valid),
        .count (fifo_count)
    );

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir |=> !q_valid);

    // R11
    data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && !mem_req && !ddone) |=> (mem_req && mem_addr == $past(daddr)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!q_valid && !mem_req));

endmodule

// File: tb/ipq_mem_model.sv
module ipq_mem_model #(
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [BUS_W-1:0]  mem_wdata,
    output logic [BUS_W-1:0]  mem_rdata,
    output logic              mem_ready,
    input  int                wait_cyc
);
    logic [7:0]  mem [256];
    logic [31:0] log_addr [64];
    logic        log_we [64];
    int          log_n;
    int          wcnt;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 13 + 7) & 255);
        mem_ready = 1'b0;
        mem_rdata = '0;
        log_n     = 0;
        wcnt      = 0;
    end

    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt      = 0;
        end else if (mem_req) begin
            if (wcnt >= wait_cyc) begin
                log_addr[log_n % 64] = 32'(mem_addr);
                log_we[log_n % 64]   = mem_we;
                log_n = log_n + 1;
                if (BUS_W == 16) begin
                    if (mem_we) begin
                        mem[{mem_addr[7:1], 1'b0}] = mem_wdata[7:0];
                        mem[{mem_addr[7:1], 1'b1}] = mem_wdata[BUS_W-1:BUS_W-8];
                    end
                    mem_rdata = BUS_W'({mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]});
                end else begin
                    if (mem_we) mem[mem_addr[7:0]] = mem_wdata[7:0];
                    mem_rdata = BUS_W'(mem[mem_addr[7:0]]);
                end
                mem_ready = 1'b1;
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

endmodule

// File: tb/ipq_unit_tb_top.sv
module ipq_unit_tb_top;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // 16-bit variant
    logic          mem_req, mem_we, mem_ready, q_valid, q_pop, dreq, dwe, ddone, redir;
    logic [AW-1:0] mem_addr, daddr, redir_addr;
    logic [15:0]   mem_wdata, mem_rdata, dwdata, drdata;
    logic [7:0]    q_byte;
    int            wait16 = 0;

    // 8-bit variant
    logic          m8_req, m8_we, m8_ready, q8_valid;
    logic [AW-1:0] m8_addr;
    logic [7:0]    m8_wdata, m8_rdata, q8_byte, d8_rdata;
    logic          d8_done;
    logic          q8_pop = 1'b0;

    ipq_unit #(.BUS_W(16), .ADDR_W(AW), .START_ADDR(20'h00100)) dut_i (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .q_byte(q_byte), .q_valid(q_valid), .q_pop(q_pop),
        .dreq(dreq), .dwe(dwe), .daddr(daddr), .dwdata(dwdata), .drdata(drdata),
        .ddone(ddone), .redir(redir), .redir_addr(redir_addr));

    ipq_mem_model #(.BUS_W(16), .ADDR_W(AW)) mdl_i (
        .clk(clk), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .wait_cyc(wait16));

    ipq_unit #(.BUS_W(8), .ADDR_W(AW), .START_ADDR(20'h00100)) dut8_i (
        .clk(clk), .rst_n(rst_n), .mem_req(m8_req), .mem_we(m8_we),
        .mem_addr(m8_addr), .mem_wdata(m8_wdata), .mem_rdata(m8_rdata),
        .mem_ready(m8_ready), .q_byte(q8_byte), .q_valid(q8_valid), .q_pop(q8_pop),
        .dreq(1'b0), .dwe(1'b0), .daddr('0), .dwdata(8'h00), .drdata(d8_rdata),
        .ddone(d8_done), .redir(1'b0), .redir_addr('0));

    ipq_mem_model #(.BUS_W(8), .ADDR_W(AW)) mdl8_i (
        .clk(clk), .mem_req(m8_req), .mem_we(m8_we), .mem_addr(m8_addr),
        .mem_wdata(m8_wdata), .mem_rdata(m8_rdata), .mem_ready(m8_ready),
        .wait_cyc(0));

    function automatic logic [7:0] bval(input logic [31:0] a);
        return 8'(((a & 255) * 13 + 7) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pop16(output logic [7:0] b, output bit ok);
        ok = 1'b0;
        b  = 8'h00;
        for (int i = 0; i < 60 && !ok; i++) begin
            @(negedge clk);
            if (q_valid) ok = 1'b1;
        end
        b     = q_byte;
        q_pop = 1'b1;
        @(negedge clk);
        q_pop = 1'b0;
    endtask

    task automatic expect_bytes(input logic [31:0] start, input int n, input string req);
        logic [7:0] b;
        bit ok;
        for (int k = 0; k < n; k++) begin
            pop16(b, ok);
            check(ok && b == bval(start + k), req, {23'd0, ok, b}, {24'd1, bval(start + k)});
        end
    endtask

    task automatic do_redir(input logic [AW-1:0] a);
        @(negedge clk);
        redir      = 1'b1;
        redir_addr = a;
        @(negedge clk);
        redir = 1'b0;
        // R7: FIFO empty in the cycle after the pulse
        check(!q_valid, "R7 flush", 32'(q_valid), 0);
    endtask

    task automatic data_access(input logic we, input logic [AW-1:0] a, input logic [15:0] wd,
                               output logic [15:0] rd);
        bit seen = 1'b0;
        @(negedge clk);
        dreq   = 1'b1;
        dwe    = we;
        daddr  = a;
        dwdata = wd;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (ddone) seen = 1'b1;
        end
        rd = drdata;
        check(seen, "R10 ddone", 32'(seen), 1);
        dreq = 1'b0;
        dwe  = 1'b0;
        @(negedge clk);
        check(!ddone, "R10 ddone one cycle", 32'(ddone), 0);
    endtask

    task automatic t_reset;
        // R1
        check(!q_valid && !mem_req, "R1 reset outputs", {30'd0, q_valid, mem_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(30);
        check(mdl_i.log_n >= 1 && mdl_i.log_addr[0] == 32'h100, "R1 first fetch",
              mdl_i.log_addr[0], 32'h100);
    endtask

    task automatic t_fill_order;
        // R2: three word fetches then the bus goes quiet
        check(mdl_i.log_n == 3 && !mem_req, "R2 depth six", 32'(mdl_i.log_n), 3);
        // R4, R5
        expect_bytes(32'h100, 6, "R4 order after reset");
    endtask

    task automatic t_threshold;
        int base;
        logic [7:0] b;
        bit ok;
        idle(30);
        base = mdl_i.log_n;
        do_redir(20'h00020);
        idle(30);
        check(mdl_i.log_n - base == 3, "R2 refill to six", 32'(mdl_i.log_n - base), 3);
        check(mdl_i.log_addr[(base + 2) % 64] == 32'h24, "R5 word addresses",
              mdl_i.log_addr[(base + 2) % 64], 32'h24);
        pop16(b, ok);
        check(ok && b == bval(32'h20), "R4 head byte", 32'(b), 32'(bval(32'h20)));
        idle(10);
        // R3: one free slot must not start a word fetch
        check(mdl_i.log_n - base == 3 && !mem_req, "R3 one slot free",
              32'(mdl_i.log_n - base), 3);
        pop16(b, ok);
        idle(10);
        check(mdl_i.log_n - base == 4, "R3 two slots free", 32'(mdl_i.log_n - base), 4);
        check(mdl_i.log_addr[(base + 3) % 64] == 32'h26, "R5 advance",
              mdl_i.log_addr[(base + 3) % 64], 32'h26);
        expect_bytes(32'h22, 6, "R4 order after refill");
    endtask

    task automatic t_odd_start;
        int base;
        idle(30);
        base = mdl_i.log_n;
        do_redir(20'h00041);
        idle(30);
        // R6
        check(mdl_i.log_n - base == 3, "R6 fetch count", 32'(mdl_i.log_n - base), 3);
        check(mdl_i.log_addr[base % 64] == 32'h41, "R6 odd first",
              mdl_i.log_addr[base % 64], 32'h41);
        check(mdl_i.log_addr[(base + 1) % 64] == 32'h42, "R6 aligned next",
              mdl_i.log_addr[(base + 1) % 64], 32'h42);
        expect_bytes(32'h41, 5, "R6 R5 lane bytes");
    endtask

    task automatic t_inflight_drop;
        bit busy = 1'b0;
        wait16 = 6;
        do_redir(20'h00060);
        for (int i = 0; i < 20 && !busy; i++) begin
            @(negedge clk);
            if (mem_req) busy = 1'b1;
        end
        check(busy, "R8 fetch in flight", 32'(busy), 1);
        do_redir(20'h00080);
        // R8: first byte is the new target, never old-address data
        expect_bytes(32'h80, 4, "R8 dropped fetch");
        wait16 = 0;
    endtask

    task automatic t_stall_empty;
        wait16 = 8;
        do_redir(20'h00030);
        q_pop = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!q_valid, "R9 stall while empty", 32'(q_valid), 0);
        end
        q_pop = 1'b0;
        expect_bytes(32'h30, 2, "R9 no byte lost");
        wait16 = 0;
    endtask

    task automatic t_data_rw;
        logic [15:0] rd;
        int base;
        idle(30);
        base = mdl_i.log_n;
        data_access(1'b0, 20'h000F0, 16'h0000, rd);
        check(rd == {bval(32'hF1), bval(32'hF0)}, "R10 load", 32'(rd),
              32'({bval(32'hF1), bval(32'hF0)}));
        check(mdl_i.log_addr[base % 64] == 32'hF0 && !mdl_i.log_we[base % 64],
              "R10 load on bus", mdl_i.log_addr[base % 64], 32'hF0);
        data_access(1'b1, 20'h000F0, 16'hA55A, rd);
        check(mdl_i.log_we[(base + 1) % 64], "R10 store on bus",
              32'(mdl_i.log_we[(base + 1) % 64]), 1);
        data_access(1'b0, 20'h000F0, 16'h0000, rd);
        check(rd == 16'hA55A, "R10 readback", 32'(rd), 32'hA55A);
    endtask

    task automatic t_preempt;
        logic [15:0] rd;
        int idx;
        bit busy = 1'b0;
        wait16 = 5;
        do_redir(20'h00050);
        for (int i = 0; i < 20 && !busy; i++) begin
            @(negedge clk);
            if (mem_req) busy = 1'b1;
        end
        idx = mdl_i.log_n;
        data_access(1'b0, 20'h000F2, 16'h0000, rd);
        // R11
        check(mdl_i.log_addr[idx % 64] == 32'h50, "R11 fetch finishes",
              mdl_i.log_addr[idx % 64], 32'h50);
        check(mdl_i.log_addr[(idx + 1) % 64] == 32'hF2, "R11 data next",
              mdl_i.log_addr[(idx + 1) % 64], 32'hF2);
        wait16 = 0;
        expect_bytes(32'h50, 3, "R11 queue intact");
    endtask

    task automatic t_narrow;
        bit ok = 1'b0;
        logic [7:0] b;
        // R2
        check(mdl8_i.log_n == 4 && !m8_req, "R2 depth four", 32'(mdl8_i.log_n), 4);
        check(mdl8_i.log_addr[3] == 32'h103, "R5 byte steps", mdl8_i.log_addr[3], 32'h103);
        @(negedge clk);
        b = q8_byte;
        ok = q8_valid;
        q8_pop = 1'b1;
        @(negedge clk);
        q8_pop = 1'b0;
        check(ok && b == bval(32'h100), "R4 narrow head", 32'(b), 32'(bval(32'h100)));
        idle(10);
        // R3: one free slot is enough on the 8-bit bus
        check(mdl8_i.log_n == 5, "R3 narrow refill", 32'(mdl8_i.log_n), 5);
        for (int k = 1; k < 5; k++) begin
            @(negedge clk);
            b = q8_byte;
            ok = q8_valid;
            q8_pop = 1'b1;
            @(negedge clk);
            q8_pop = 1'b0;
            check(ok && b == bval(32'h100 + k), "R4 narrow order", 32'(b), 32'(bval(32'h100 + k)));
        end
    endtask

    initial begin
        q_pop = 1'b0; dreq = 1'b0; dwe = 1'b0; daddr = '0; dwdata = '0;
        redir = 1'b0; redir_addr = '0;
        idle(4);
        t_reset;
        t_fill_order;
        t_threshold;
        t_odd_start;
        t_inflight_drop;
        t_stall_empty;
        t_data_rw;
        t_preempt;
        t_narrow;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule